// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block sits between a raster timing generator and a memory read master in a display pipeline. On every pixel clock it takes the current screen position and, for each of two overlay windows, decides whether that position lies inside the window's on-screen rectangle. When it does, the block forms the byte address in the frame buffer where that window's pixel is stored. Window 0 is the primary plane. Window 1 is the cursor plane and sits in front of it.

Each window is described by the following settings:
- an enable
- a pixel-size select
- a buffer base address
- a line pitch in bytes
- a buffer height in lines
- a source x/y offset into the buffer
- an on-screen position and size

From the position and size the block derives an inclusive bottom-right corner. From the pitch it derives the padded line stride in pixels. The stride also chooses the burst length the read master should use for that window. All results are registered and appear one clock after the inputs that produced them.

Top module: `ovl_fetch_gen`

## Requirements
- R1: While `rstN` is low, every hit flag, every fetch address, every burst flag, `frontValid` and `frontWin` are zero.
- R2: The inclusive bottom-right corner on each axis is position + size − 1, computed one bit wider than the coordinates. When position + size is zero the corner is 0, so a window at position 0 with size 0 covers pixel 0 only.
- R3: `winHit[w]` is 1 in the cycle after an edge at which all of the following were true, and 0 otherwise:
  - `rasterValid` was 1.
  - `winEnable[w]` was 1.
  - The raster x lay between position x and corner x, inclusive.
  - The raster y lay between position y and corner y, inclusive.
- R4: A window with `winEnable[w]`=0 never hits, and no window hits when `rasterValid`=0.
- R5: The line stride in pixels is the pitch divided by the bytes per pixel. Bytes per pixel is 2 when `winWide[w]`=0 (16-bit formats) and 4 when `winWide[w]`=1 (24- and 32-bit formats).
- R6: On a hit, `winAddr[w]` becomes `base + ((srcY + line) * stride + srcX + column) * bytesPerPixel` modulo 2^ADDR_W, where line and column are the raster offsets from the window's top-left corner. It changes in the same cycle as `winHit[w]` rises.
- R7: In a cycle after an edge where window w did not hit, `winAddr[w]` keeps its previous value.
- R8: `winBurst16[w]` is registered every cycle. It is 1 (16-word bursts) when the stride is at least 128 pixels, and 0 (8-word bursts) below that.
- R9: `frontValid` is 1 when any window hits. `frontWin` holds the highest-numbered hitting window, so the cursor (1) is reported over the primary (0). `frontWin` is 0 when nothing hits.
- R10: A position inside the rectangle does not hit when srcY + line is not less than the buffer height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasterValid | input | 1 | Raster position is in the active area |
| rasterX | input | COORD_W | Current raster column |
| rasterY | input | COORD_W | Current raster line |
| winEnable | input | NUM_WIN | Per-window enable |
| winWide | input | NUM_WIN | Pixel size: 0 = 2 bytes, 1 = 4 bytes |
| winBase | input | NUM_WIN×ADDR_W | Buffer start address in bytes |
| winPitch | input | NUM_WIN×PITCH_W | Buffer line pitch in bytes, padding included |
| winHeight | input | NUM_WIN×COORD_W | Buffer height in lines |
| winSrcX | input | NUM_WIN×COORD_W | Source column offset into the buffer |
| winSrcY | input | NUM_WIN×COORD_W | Source line offset into the buffer |
| winPosX | input | NUM_WIN×COORD_W | On-screen left edge |
| winPosY | input | NUM_WIN×COORD_W | On-screen top edge |
| winSizeW | input | NUM_WIN×COORD_W | On-screen width |
| winSizeH | input | NUM_WIN×COORD_W | On-screen height |
| winHit | output | NUM_WIN | Raster pixel lies inside the window |
| winAddr | output | NUM_WIN×ADDR_W | Fetch byte address for the window's pixel |
| winBurst16 | output | NUM_WIN | 1 = 16-word bursts, 0 = 8-word bursts |
| frontValid | output | 1 | At least one window hits |
| frontWin | output | IDX_W | Frontmost hitting window |

## Verification
The assertions check four rules on every cycle:
- A hit never appears without a valid raster position and an enabled window.
- The fetch address does not move when its window misses.
- The burst flag always follows the stride threshold of the previous cycle's pitch and pixel size.
- The front-window outputs stay consistent with the hit flags.

Some behaviours are left to the bench scenarios, which compare every output against a behavioural model each clock:
- the exact rectangle boundaries
- the zero-sum and wide-sum corner cases
- the buffer-height cut-off
- the address arithmetic for both pixel sizes
- the 127/128-pixel burst boundary

// File: rtl/ovl_fetch_pkg.sv
package ovl_fetch_pkg;

  // Per-window strobes passed from the control half to the datapath.
  typedef struct packed {
    logic load;  // capture a new fetch address this cycle
    logic wide;  // 4-byte pixels when set, 2-byte pixels otherwise
  } winStrobe_t;

endpackage

// File: rtl/ovl_fetch_ctrl.sv
module ovl_fetch_ctrl
  import ovl_fetch_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int COORD_W = 12,
  parameter int IDX_W   = 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              rasterValid,
  input  logic [COORD_W-1:0]                rasterX,
  input  logic [COORD_W-1:0]                rasterY,
  input  logic [NUM_WIN-1:0]                winEnable,
  input  logic [NUM_WIN-1:0]                winWide,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winHeight,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSrcY,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winPosX,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winPosY,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSizeW,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSizeH,
  output winStrobe_t [NUM_WIN-1:0]          strobe,
  output logic [NUM_WIN-1:0]                winHit,
  output logic                              frontValid,
  output logic [IDX_W-1:0]                  frontWin
);

  localparam int EXT_W = COORD_W + 1;

  logic [NUM_WIN-1:0] hitNext;
  logic [IDX_W-1:0]   frontNext;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [EXT_W-1:0]   sumX, sumY, cornerX, cornerY, srcLine;
    logic [COORD_W-1:0] lineRel;
    logic               inX, inY, lineOk;

    // Inclusive far corner; a zero sum stays at zero instead of wrapping.
    assign sumX    = {1'b0, winPosX[w]} + {1'b0, winSizeW[w]};
    assign sumY    = {1'b0, winPosY[w]} + {1'b0, winSizeH[w]};
    assign cornerX = (sumX == '0) ? '0 : sumX - EXT_W'(1);
    assign cornerY = (sumY == '0) ? '0 : sumY - EXT_W'(1);

    assign inX = ({1'b0, rasterX} >= {1'b0, winPosX[w]}) && ({1'b0, rasterX} <= cornerX);
    assign inY = ({1'b0, rasterY} >= {1'b0, winPosY[w]}) && ({1'b0, rasterY} <= cornerY);

    // Buffer line that would be read; it must lie inside the buffer.
    assign lineRel = rasterY - winPosY[w];
    assign srcLine = {1'b0, winSrcY[w]} + {1'b0, lineRel};
    assign lineOk  = srcLine < {1'b0, winHeight[w]};

    assign hitNext[w]     = rasterValid & winEnable[w] & inX & inY & lineOk;
    assign strobe[w].load = hitNext[w];
    assign strobe[w].wide = winWide[w];
  end

  // Higher index is stacked in front, so it overrides lower ones.
  always_comb begin
    frontNext = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hitNext[i]) frontNext = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winHit     <= '0;
      frontValid <= 1'b0;
      frontWin   <= '0;
    end else begin
      winHit     <= hitNext;
      frontValid <= |hitNext;
      frontWin   <= frontNext;
    end
  end

endmodule

// File: rtl/ovl_fetch_dp.sv
module ovl_fetch_dp
  import ovl_fetch_pkg::*;
#(
  parameter int NUM_WIN        = 2,
  parameter int COORD_W        = 12,
  parameter int PITCH_W        = 16,
  parameter int ADDR_W         = 32,
  parameter int MIN_BURST_LINE = 128
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  winStrobe_t [NUM_WIN-1:0]          strobe,
  input  logic [COORD_W-1:0]                rasterX,
  input  logic [COORD_W-1:0]                rasterY,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    winBase,
  input  logic [NUM_WIN-1:0][PITCH_W-1:0]   winPitch,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSrcX,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSrcY,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winPosX,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winPosY,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    winAddr,
  output logic [NUM_WIN-1:0]                winBurst16
);

  localparam int EXT_W = COORD_W + 1;
  localparam int PIX_W = EXT_W + PITCH_W + 1;
  localparam int OFF_W = PIX_W + 2;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [PITCH_W-1:0] stride;
    logic [COORD_W-1:0] lineRel, colRel;
    logic [EXT_W-1:0]   lineIdx, colIdx;
    logic [PIX_W-1:0]   pixIdx;
    logic [OFF_W-1:0]   byteOff;
    logic [ADDR_W-1:0]  addrNext;
    logic               burstNext;

    // Padded line in pixels: pitch in bytes over bytes per pixel.
    assign stride  = strobe[w].wide ? (winPitch[w] >> 2) : (winPitch[w] >> 1);

    assign lineRel = rasterY - winPosY[w];
    assign colRel  = rasterX - winPosX[w];
    assign lineIdx = {1'b0, winSrcY[w]} + {1'b0, lineRel};
    assign colIdx  = {1'b0, winSrcX[w]} + {1'b0, colRel};

    assign pixIdx   = PIX_W'(lineIdx) * PIX_W'(stride) + PIX_W'(colIdx);
    assign byteOff  = strobe[w].wide ? {pixIdx, 2'b00} : {1'b0, pixIdx, 1'b0};
    assign addrNext = winBase[w] + ADDR_W'(byteOff);

    assign burstNext = stride >= PITCH_W'(MIN_BURST_LINE);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winAddr[w]    <= '0;
        winBurst16[w] <= 1'b0;
      end else begin
        winBurst16[w] <= burstNext;
        if (strobe[w].load) winAddr[w] <= addrNext;
      end
    end
  end

endmodule

// File: rtl/ovl_fetch_gen.sv
module ovl_fetch_gen
  import ovl_fetch_pkg::*;
#(
  parameter int NUM_WIN        = 2,
  parameter int COORD_W        = 12,
  parameter int PITCH_W        = 16,
  parameter int ADDR_W         = 32,
  parameter int MIN_BURST_LINE = 128,
  localparam int IDX_W         = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              rasterValid,
  input  logic [COORD_W-1:0]                rasterX,
  input  logic [COORD_W-1:0]                rasterY,
  input  logic [NUM_WIN-1:0]                winEnable,
  input  logic [NUM_WIN-1:0]                winWide,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    winBase,
  input  logic [NUM_WIN-1:0][PITCH_W-1:0]   winPitch,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winHeight,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSrcX,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSrcY,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winPosX,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winPosY,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSizeW,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   winSizeH,
  output logic [NUM_WIN-1:0]                winHit,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]    winAddr,
  output logic [NUM_WIN-1:0]                winBurst16,
  output logic                              frontValid,
  output logic [IDX_W-1:0]                  frontWin
);

  winStrobe_t [NUM_WIN-1:0] strobe;

  ovl_fetch_ctrl #(
    .NUM_WIN(NUM_WIN), .COORD_W(COORD_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rasterValid(rasterValid),
    .rasterX(rasterX), .rasterY(rasterY),
    .winEnable(winEnable), .winWide(winWide), .winHeight(winHeight),
    .winSrcY(winSrcY), .winPosX(winPosX), .winPosY(winPosY),
    .winSizeW(winSizeW), .winSizeH(winSizeH),
    .strobe(strobe), .winHit(winHit),
    .frontValid(frontValid), .frontWin(frontWin)
  );

  ovl_fetch_dp #(
    .NUM_WIN(NUM_WIN), .COORD_W(COORD_W), .PITCH_W(PITCH_W),
    .ADDR_W(ADDR_W), .MIN_BURST_LINE(MIN_BURST_LINE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rasterX(rasterX), .rasterY(rasterY),
    .winBase(winBase), .winPitch(winPitch),
    .winSrcX(winSrcX), .winSrcY(winSrcY),
    .winPosX(winPosX), .winPosY(winPosY),
    .winAddr(winAddr), .winBurst16(winBurst16)
  );

endmodule

// File: rtl/ovl_fetch_checker.sv
module ovl_fetch_checker #(
  parameter int NUM_WIN        = 2,
  parameter int PITCH_W        = 16,
  parameter int ADDR_W         = 32,
  parameter int IDX_W          = 1,
  parameter int MIN_BURST_LINE = 128
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            rasterValid,
  input logic [NUM_WIN-1:0]              winEnable,
  input logic [NUM_WIN-1:0]              winWide,
  input logic [NUM_WIN-1:0][PITCH_W-1:0] winPitch,
  input logic [NUM_WIN-1:0]              winHit,
  input logic [NUM_WIN-1:0][ADDR_W-1:0]  winAddr,
  input logic [NUM_WIN-1:0]              winBurst16,
  input logic                            frontValid,
  input logic [IDX_W-1:0]                frontWin
);

  // Set once a clock edge has passed with reset released.
  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rstN)
      (seen && winHit[w]) |-> ($past(rasterValid) && $past(winEnable[w]))); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (seen && !winHit[w]) |-> (winAddr[w] == $past(winAddr[w]))); // R7

    AST_BURST_RULE: assert property (@(posedge clk) disable iff (!rstN)
      seen |-> (winBurst16[w] ==
        (($past(winWide[w]) ? ($past(winPitch[w]) >> 2) : ($past(winPitch[w]) >> 1))
          >= PITCH_W'(MIN_BURST_LINE)))); // R8
  end

  AST_FRONT_ANY: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> (frontValid == (|winHit))); // R9

  AST_FRONT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (seen && winHit[NUM_WIN-1]) |-> (frontWin == IDX_W'(NUM_WIN - 1))); // R9

  AST_FRONT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !frontValid) |-> (frontWin == '0)); // R9

endmodule

bind ovl_fetch_gen ovl_fetch_checker #(
  .NUM_WIN(NUM_WIN), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W),
  .IDX_W(IDX_W), .MIN_BURST_LINE(MIN_BURST_LINE)
) u_chk (.*);

// File: tb/tb_ovl_fetch_gen.sv
`timescale 1ns/1ps
module tb_ovl_fetch_gen;

  localparam int NW = 2;
  localparam int CW = 12;
  localparam int PW = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN;
  logic rasterValid;
  logic [CW-1:0] rasterX, rasterY;
  logic [NW-1:0] winEnable, winWide;
  logic [NW-1:0][AW-1:0] winBase;
  logic [NW-1:0][PW-1:0] winPitch;
  logic [NW-1:0][CW-1:0] winHeight, winSrcX, winSrcY, winPosX, winPosY, winSizeW, winSizeH;
  logic [NW-1:0] winHit;
  logic [NW-1:0][AW-1:0] winAddr;
  logic [NW-1:0] winBurst16;
  logic frontValid;
  logic [0:0] frontWin;

  ovl_fetch_gen dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int compared = 0;
  int mismatched = 0;
  string hitTag = "R1", addrTag = "R1", burstTag = "R1";
  string eHitTag, eAddrTag, eBurstTag;

  // Reference state, updated at each rising edge.
  bit     live = 1'b0;
  bit     eHit [NW];
  longint eAddr [NW];
  bit     eBurst [NW];
  bit     eFrontValid;
  int     eFrontWin;

  always @(posedge clk) begin
    live = 1'b1;
    eHitTag = rstN ? hitTag : "R1";
    eAddrTag = rstN ? addrTag : "R1";
    eBurstTag = rstN ? burstTag : "R1";
    eFrontValid = 1'b0;
    eFrontWin = 0;
    for (int w = 0; w < NW; w++) begin
      int px, py, cx, cy, sumv, line, col, bpp, stride, srcLine;
      if (!rstN) begin
        eHit[w] = 1'b0; eAddr[w] = 0; eBurst[w] = 1'b0;
      end else begin
        bpp = winWide[w] ? 4 : 2;
        stride = int'(winPitch[w]) / bpp;
        px = winPosX[w]; py = winPosY[w];
        sumv = px + int'(winSizeW[w]); cx = (sumv == 0) ? 0 : sumv - 1;
        sumv = py + int'(winSizeH[w]); cy = (sumv == 0) ? 0 : sumv - 1;
        line = (int'(rasterY) - py) & 32'hFFF;
        col  = (int'(rasterX) - px) & 32'hFFF;
        srcLine = int'(winSrcY[w]) + line;
        eHit[w] = rasterValid && winEnable[w] && rasterX >= px && rasterX <= cx &&
                  rasterY >= py && rasterY <= cy && srcLine < int'(winHeight[w]);
        if (eHit[w])
          eAddr[w] = (longint'(winBase[w]) +
                      (longint'(srcLine) * stride + winSrcX[w] + col) * bpp) & 64'hFFFF_FFFF;
        eBurst[w] = stride >= 128;
        if (eHit[w]) begin eFrontValid = 1'b1; eFrontWin = w; end
      end
    end
  end

  task automatic report(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      for (int w = 0; w < NW; w++) begin
        report(eHitTag, $sformatf("hit[%0d]", w), longint'(winHit[w]), longint'(eHit[w]));
        report(eAddrTag, $sformatf("addr[%0d]", w), longint'(winAddr[w]), eAddr[w]);
        report(eBurstTag, $sformatf("burst16[%0d]", w), longint'(winBurst16[w]), longint'(eBurst[w]));
      end
      report(rstN ? "R9" : "R1", "frontValid", longint'(frontValid), longint'(eFrontValid));
      report(rstN ? "R9" : "R1", "frontWin", longint'(frontWin), longint'(eFrontWin));
    end
  end

  task automatic setWin(int w, bit en, bit wide, longint base, int pitch, int height,
                        int sx, int sy, int px, int py, int sw, int sh);
    winEnable[w] = en; winWide[w] = wide; winBase[w] = AW'(base);
    winPitch[w] = PW'(pitch); winHeight[w] = CW'(height);
    winSrcX[w] = CW'(sx); winSrcY[w] = CW'(sy);
    winPosX[w] = CW'(px); winPosY[w] = CW'(py);
    winSizeW[w] = CW'(sw); winSizeH[w] = CW'(sh);
  endtask

  task automatic at(int x, int y, bit v);
    @(negedge clk);
    rasterX = CW'(x); rasterY = CW'(y); rasterValid = v;
  endtask

  task automatic scan(int x0, int x1, int y0, int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) at(x, y, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; rasterValid = 1'b0; rasterX = '0; rasterY = '0;
    setWin(0, 1, 1, 64'h1000_0000, 640, 100, 3, 2, 10, 5, 20, 8);
    setWin(1, 1, 0, 64'h2000_0000, 64, 4, 0, 0, 20, 8, 4, 4);
    at(5, 5, 1'b1);  // R1: inputs active while reset held
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    hitTag = "R3"; addrTag = "R6"; burstTag = "R8";
    // R3 R6 R9: overlapping windows across their edges
    scan(8, 32, 3, 14);
    // R7: leave, touch one pixel, leave again
    addrTag = "R7";
    at(0, 0, 1'b1); at(40, 40, 1'b1); at(12, 6, 1'b1); at(0, 0, 1'b1); at(2, 30, 1'b1);
    // R4: disabled window and invalid raster
    hitTag = "R4";
    winEnable[0] = 1'b0;
    scan(8, 32, 6, 6);
    winEnable[0] = 1'b1;
    for (int x = 8; x <= 32; x++) at(x, 9, 1'b0);
    // R10: buffer height cuts rows
    hitTag = "R10"; addrTag = "R6";
    setWin(1, 1, 0, 64'h2000_0000, 64, 3, 1, 1, 20, 8, 4, 4);
    scan(19, 24, 7, 12);
    // R2: zero-sum corner, empty window, wide sum
    hitTag = "R2";
    setWin(0, 1, 1, 64'h3000_0000, 400, 4095, 0, 0, 0, 0, 0, 0);
    setWin(1, 1, 1, 64'h4000_0000, 400, 4095, 0, 0, 5, 5, 0, 0);
    scan(0, 6, 0, 6);
    setWin(0, 1, 1, 64'h3000_0000, 400, 4095, 0, 0, 4090, 0, 10, 1);
    scan(4085, 4095, 0, 1);
    // R5 R8: stride from pitch and pixel size, around 128 pixels
    hitTag = "R3"; addrTag = "R5"; burstTag = "R8";
    setWin(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setWin(0, 1, 0, 64'h0500_0000, 254, 50, 1, 1, 0, 0, 8, 8);
    at(3, 2, 1'b1); at(3, 2, 1'b1);
    winPitch[0] = 16'd255; at(3, 2, 1'b1); at(3, 2, 1'b1);
    winPitch[0] = 16'd256; at(3, 2, 1'b1); at(3, 2, 1'b1);
    winWide[0] = 1'b1; winPitch[0] = 16'd508; at(3, 2, 1'b1); at(3, 2, 1'b1);
    winPitch[0] = 16'd512; at(5, 7, 1'b1); at(5, 7, 1'b1);
    // R1: reset asserted mid-run
    rstN = 1'b0;
    at(3, 2, 1'b1); at(3, 2, 1'b1);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule